// File: doc/BRIEF.md
# Width-Aliased Floating-Point and Vector Register File

This block stores the floating-point and vector architectural state of a core. It has 32 physical entries, and three register views of increasing width share that storage. The scalar view covers the low 64 bits of an entry. The short-vector view covers the low 128 bits. The long-vector view covers all 256 bits. Scalar register n is therefore the bottom of short-vector register n, and short-vector register n is the bottom of long-vector register n.

The block has one write port and two read ports. Each port carries a register index and a view code. A write through a narrow view replaces only the bits that view covers, and the upper bits of the entry keep their value. A read returns the bits its view covers, zero-extended to the 256-bit port. Reads are combinational and write-first: a read of the entry being written in the same cycle already shows the new bits wherever the two views overlap.

Parameters can drop the short-vector view, the long-vector view, or both. The storage for the bits that only a removed view reaches is then not built. A write through a removed view, or through the reserved view code, changes nothing and raises a one-cycle flag.

Top module: `vrf_alias_top`

## Requirements
- R1: After reset is released, every entry reads as all zeros through every view on both read ports.
- R2: A write with view code 2 (long vector, 256 bits) followed by a long-view read of the same index returns all 256 written bits.
- R3: A write with view code 0 (scalar, 64 bits) replaces bits 63:0 of the entry and leaves bits 255:64 unchanged.
- R4: A write with view code 1 (short vector, 128 bits) replaces bits 127:0 of the entry and leaves bits 255:128 unchanged.
- R5: A read with view code 0 returns entry bits 63:0 with output bits 255:64 at zero. A read with view code 1 returns bits 127:0 with output bits 255:128 at zero.
- R6: When a read and a legal write target the same index in the same cycle, the read data shows the new write data on the bits both views cover, and the stored data on the other bits.
- R7: When we_i is low, no entry changes.
- R8: A write with view code 3, or with the code of a view that is disabled by parameter, leaves every entry unchanged. It drives illegal_o high for exactly the one cycle after the write's clock edge. illegal_o is low otherwise and after reset.
- R9: The two read ports are independent: each returns data for its own index and view in the same cycle.
- R10: A read with view code 3, or with the code of a disabled view, returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write request |
| waddr_i | input | 5 | Write register index |
| wview_i | input | 2 | Write view: 0 scalar, 1 short, 2 long, 3 reserved |
| wdata_i | input | 256 | Write data, low bits used by narrow views |
| raddr0_i | input | 5 | Read port 0 index |
| rview0_i | input | 2 | Read port 0 view |
| rdata0_o | output | 256 | Read port 0 data, zero-extended |
| raddr1_i | input | 5 | Read port 1 index |
| rview1_i | input | 2 | Read port 1 view |
| rdata1_o | output | 256 | Read port 1 data, zero-extended |
| illegal_o | output | 1 | One-cycle flag for a rejected write |

## Verification
The hardest case to reach is a same-cycle bypass where the write view and the read view differ. Examples are a scalar write seen through a long read, where the upper bits must come from storage and the lower bits from the write bus, and a long write seen through a scalar read. Directed steps set up each view pairing on one index, with the two ports reading through different views. A long random phase draws indices from a small pool so that collisions, overlays and reserved-code writes happen often. A behavioural model holds the full 256-bit image of every entry, and both ports are compared with it every cycle.

// File: rtl/vrf_alias_pkg.sv
package vrf_alias_pkg;
  typedef enum logic [1:0] {
    VIEW_FP    = 2'd0,
    VIEW_SHORT = 2'd1,
    VIEW_LONG  = 2'd2,
    VIEW_RSVD  = 2'd3
  } view_e;

  localparam int unsigned NUM_SEGS = 3;
endpackage

// File: rtl/vrf_view_decode.sv
module vrf_view_decode
  import vrf_alias_pkg::*;
#(
  parameter bit EN_SHORT = 1'b1,
  parameter bit EN_LONG  = 1'b1
) (
  input  logic [1:0]          view_i,
  output logic                legal_o,
  output logic [NUM_SEGS-1:0] seg_o
);
  view_e view;
  assign view = view_e'(view_i);

  // seg_o[k]: view reaches segment k (0: 63:0, 1: 127:64, 2: 255:128)
  always_comb begin
    legal_o = 1'b0;
    seg_o   = '0;
    unique case (view)
      VIEW_FP: begin
        legal_o = 1'b1;
        seg_o   = 3'b001;
      end
      VIEW_SHORT: if (EN_SHORT) begin
        legal_o = 1'b1;
        seg_o   = 3'b011;
      end
      VIEW_LONG: if (EN_LONG) begin
        legal_o = 1'b1;
        seg_o   = 3'b111;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vrf_seg_bank.sv
module vrf_seg_bank #(
  parameter int unsigned W  = 64,
  parameter int unsigned N  = 32,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // write-first bypass per segment
  assign rdata_a_o = (we_i && waddr_i == raddr_a_i) ? wdata_i : mem[raddr_a_i];
  assign rdata_b_o = (we_i && waddr_i == raddr_b_i) ? wdata_i : mem[raddr_b_i];

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem[$past(raddr_a_i)] == $past(rdata_a_o));
endmodule

// File: rtl/vrf_alias_top.sv
module vrf_alias_top
  import vrf_alias_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned FP_W     = 64,
  parameter int unsigned SHORT_W  = 128,
  parameter int unsigned LONG_W   = 256,
  parameter bit          EN_SHORT = 1'b1,
  parameter bit          EN_LONG  = 1'b1,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned SEG1_W  = SHORT_W - FP_W,
  localparam int unsigned SEG2_W  = LONG_W - SHORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [1:0]        wview_i,
  input  logic [LONG_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr0_i,
  input  logic [1:0]        rview0_i,
  output logic [LONG_W-1:0] rdata0_o,
  input  logic [AW-1:0]     raddr1_i,
  input  logic [1:0]        rview1_i,
  output logic [LONG_W-1:0] rdata1_o,
  output logic              illegal_o
);
  logic                wlegal, rlegal0, rlegal1;
  logic [NUM_SEGS-1:0] wseg, rseg0, rseg1, seg_we;

  vrf_view_decode #(.EN_SHORT(EN_SHORT), .EN_LONG(EN_LONG)) u_wdec (
    .view_i(wview_i), .legal_o(wlegal), .seg_o(wseg));
  vrf_view_decode #(.EN_SHORT(EN_SHORT), .EN_LONG(EN_LONG)) u_rdec0 (
    .view_i(rview0_i), .legal_o(rlegal0), .seg_o(rseg0));
  vrf_view_decode #(.EN_SHORT(EN_SHORT), .EN_LONG(EN_LONG)) u_rdec1 (
    .view_i(rview1_i), .legal_o(rlegal1), .seg_o(rseg1));

  assign seg_we = {NUM_SEGS{we_i & wlegal}} & wseg;

  logic [FP_W-1:0]   s0_a, s0_b;
  logic [SEG1_W-1:0] s1_a, s1_b;
  logic [SEG2_W-1:0] s2_a, s2_b;

  vrf_seg_bank #(.W(FP_W), .N(NUM_REGS), .AW(AW)) u_seg0 (
    .clk_i, .rst_ni, .we_i(seg_we[0]), .waddr_i,
    .wdata_i(wdata_i[FP_W-1:0]),
    .raddr_a_i(raddr0_i), .raddr_b_i(raddr1_i),
    .rdata_a_o(s0_a), .rdata_b_o(s0_b));

  generate
    if (EN_SHORT || EN_LONG) begin : g_seg1
      vrf_seg_bank #(.W(SEG1_W), .N(NUM_REGS), .AW(AW)) u_seg1 (
        .clk_i, .rst_ni, .we_i(seg_we[1]), .waddr_i,
        .wdata_i(wdata_i[SHORT_W-1:FP_W]),
        .raddr_a_i(raddr0_i), .raddr_b_i(raddr1_i),
        .rdata_a_o(s1_a), .rdata_b_o(s1_b));
    end else begin : g_no_seg1
      assign s1_a = '0;
      assign s1_b = '0;
    end
    if (EN_LONG) begin : g_seg2
      vrf_seg_bank #(.W(SEG2_W), .N(NUM_REGS), .AW(AW)) u_seg2 (
        .clk_i, .rst_ni, .we_i(seg_we[2]), .waddr_i,
        .wdata_i(wdata_i[LONG_W-1:SHORT_W]),
        .raddr_a_i(raddr0_i), .raddr_b_i(raddr1_i),
        .rdata_a_o(s2_a), .rdata_b_o(s2_b));
    end else begin : g_no_seg2
      assign s2_a = '0;
      assign s2_b = '0;
    end
  endgenerate

  // zero-extend: mask segments the read view does not cover
  assign rdata0_o = {s2_a & {SEG2_W{rseg0[2]}}, s1_a & {SEG1_W{rseg0[1]}},
                     s0_a & {FP_W{rseg0[0]}}};
  assign rdata1_o = {s2_b & {SEG2_W{rseg1[2]}}, s1_b & {SEG1_W{rseg1[1]}},
                     s0_b & {FP_W{rseg1[0]}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= we_i & ~wlegal;
  end

  p_illegal_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(we_i) && $past(wview_i) == 2'd3 || !$past(wlegal));

  p_zero_ext_fp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rview0_i == 2'd0 |-> rdata0_o[LONG_W-1:FP_W] == '0);

  p_zero_ext_short_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rview1_i == 2'd1 |-> rdata1_o[LONG_W-1:SHORT_W] == '0);

  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rlegal0 |-> rdata0_o == '0);

  p_bad_read_zero_port1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rlegal1 |-> rdata1_o == '0);
endmodule

// File: tb/tb_vrf_alias_top.sv
`timescale 1ns/1ps
module tb_vrf_alias_top;
  localparam int N = 32;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   waddr = '0, ra0 = '0, ra1 = '0;
  logic [1:0]   wview = '0, rv0 = '0, rv1 = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rd0, rd1;
  logic         illegal;

  int checks = 0;
  int errors = 0;
  bit exp_ill = 1'b0;
  logic [W-1:0] model [N];

  always #5 clk = ~clk;

  vrf_alias_top dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wview_i(wview),
    .wdata_i(wdata), .raddr0_i(ra0), .rview0_i(rv0), .rdata0_o(rd0),
    .raddr1_i(ra1), .rview1_i(rv1), .rdata1_o(rd1), .illegal_o(illegal));

  function automatic logic [W-1:0] vmask(input logic [1:0] v);
    case (v)
      2'd0:    return {192'd0, {64{1'b1}}};
      2'd1:    return {128'd0, {128{1'b1}}};
      2'd2:    return {W{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] expect_rd(input logic [4:0] a, input logic [1:0] v);
    logic [W-1:0] val;
    logic [W-1:0] m;
    val = model[a];
    if (we && wview != 2'd3 && waddr == a) begin
      m = vmask(wview);
      val = (val & ~m) | (wdata & m);
    end
    return val & vmask(v);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit w, input logic [4:0] wa,
                      input logic [1:0] wv, input logic [W-1:0] wd,
                      input logic [4:0] a0, input logic [1:0] v0,
                      input logic [4:0] a1, input logic [1:0] v1);
    @(negedge clk);
    we = w; waddr = wa; wview = wv; wdata = wd;
    ra0 = a0; rv0 = v0; ra1 = a1; rv1 = v1;
    chk({req, " illegal R8"}, {255'd0, illegal}, {255'd0, exp_ill});
    #2;
    chk({req, " port0"}, rd0, expect_rd(a0, v0));
    chk({req, " port1 R9"}, rd1, expect_rd(a1, v1));
    @(posedge clk);
    if (w && wv != 2'd3) model[wa] = (model[wa] & ~vmask(wv)) | (wd & vmask(wv));
    exp_ill = w && (wv == 2'd3);
  endtask

  function automatic logic [W-1:0] pat(input int s);
    logic [W-1:0] p;
    for (int k = 0; k < 8; k++) p[k*32 +: 32] = 32'h9E37_79B9 * (s * 8 + k + 1);
    return p;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents through every view
    for (int i = 0; i < N; i++) step("R1", 0, 0, 0, '0, i[4:0], 2'd2, i[4:0], i[1:0]);
    // R2: full long write and read
    step("R2", 1, 5'd5, 2'd2, pat(1), 5'd0, 2'd2, 5'd1, 2'd0);
    step("R2", 0, 0, 0, '0, 5'd5, 2'd2, 5'd5, 2'd1);
    // R3: scalar overlay keeps upper bits
    step("R3", 1, 5'd5, 2'd0, pat(2), 5'd6, 2'd2, 5'd7, 2'd2);
    step("R3", 0, 0, 0, '0, 5'd5, 2'd2, 5'd5, 2'd0);
    // R4: short overlay keeps upper bits
    step("R4", 1, 5'd5, 2'd1, pat(3), 5'd6, 2'd2, 5'd7, 2'd2);
    step("R4", 0, 0, 0, '0, 5'd5, 2'd2, 5'd5, 2'd1);
    // R5: zero extension of narrow reads
    step("R5", 0, 0, 0, '0, 5'd5, 2'd0, 5'd5, 2'd1);
    // R6: same-cycle bypass, mixed views
    step("R6", 1, 5'd9, 2'd2, pat(4), 5'd9, 2'd0, 5'd9, 2'd2);
    step("R6", 1, 5'd9, 2'd0, pat(5), 5'd9, 2'd2, 5'd9, 2'd1);
    step("R6", 1, 5'd9, 2'd1, pat(6), 5'd9, 2'd2, 5'd9, 2'd0);
    // R7: write enable low
    step("R7", 0, 5'd9, 2'd2, pat(7), 5'd9, 2'd2, 5'd9, 2'd2);
    step("R7", 0, 0, 0, '0, 5'd9, 2'd2, 5'd5, 2'd2);
    // R8: reserved-view write ignored and flagged
    step("R8", 1, 5'd9, 2'd3, pat(8), 5'd9, 2'd2, 5'd9, 2'd2);
    step("R8", 0, 0, 0, '0, 5'd9, 2'd2, 5'd9, 2'd0);
    step("R8", 0, 0, 0, '0, 5'd9, 2'd2, 5'd9, 2'd0);
    // R10: reserved-view read
    step("R10", 0, 0, 0, '0, 5'd9, 2'd3, 5'd5, 2'd3);
    // R9: independent ports
    step("R9", 0, 0, 0, '0, 5'd5, 2'd1, 5'd9, 2'd2);
    // random mix over a small index pool
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a, b, c;
      logic [1:0] vw;
      a  = 5'($urandom_range(0, 5));
      b  = 5'($urandom_range(0, 5));
      c  = 5'($urandom_range(0, 5));
      vw = 2'($urandom_range(0, 3));
      step((a == b || a == c) ? "R6" : "R2", 1'($urandom_range(0, 1)), a, vw,
           pat(n + 100), b, 2'($urandom_range(0, 3)), c, 2'($urandom_range(0, 3)));
    end
    step("R8", 0, 0, 0, '0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule